// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block generates the serial clock for an SPI transfer engine from the module clock. A 32-bit clock control word selects one of two divide laws. The linear law divides by 2×(N+1), with an 8-bit N. The power-of-two law divides by 2^E, with a 4-bit E. The block produces two outputs:

- a one-cycle toggle strobe at twice the serial clock rate;
- a level output that follows the serial clock, which the engine can sample or drive onto the wire.

The transfer engine raises the enable input for the whole of a transfer. While the enable is low, the divider is held cleared and the clock output stays idle. A new control word takes effect only at the end of a full serial clock period, so no shortened pulse appears on the serial clock. Choosing a divide value for a target frequency is software's job and is not part of this block.

Top module: `sclk_divider`

## Requirements
- R1: When bit 12 of `clk_ctrl` is 1 (linear law), each half-period of `sclk_lvl` lasts N+1 module clocks, where N is `clk_ctrl[7:0]`. N = 0 gives half the module clock rate.
- R2: When bit 12 of `clk_ctrl` is 0 (power-of-two law), each half-period lasts 2^(E−1) module clocks, where E is `clk_ctrl[11:8]`.
- R3: Bit 12 alone chooses the law. Under the linear law, the E field has no effect. Under the power-of-two law, the N field has no effect.
- R4: Under the power-of-two law, E = 0 behaves exactly like E = 1: the half-period is one module clock.
- R5: After reset, and in every cycle that follows a cycle with `en` low, `sclk_lvl` is 0. `sclk_tick` is 0 whenever `en` is low.
- R6: When `en` rises, `sclk_lvl` starts at 0. Counting the first cycle with `en` high as cycle 0, the first `sclk_tick` is asserted in cycle H−1, where H is the half-period.
- R7: `sclk_tick` is asserted in the last cycle of every half-period. `sclk_lvl` toggles on the clock edge that ends that cycle, and holds its value otherwise. The result is a 50% duty cycle.
- R8: A change to `clk_ctrl` during a transfer is picked up only on the edge that ends a full period: the tick cycle in which `sclk_lvl` is 1. A change made and withdrawn inside one period has no effect.
- R9: Bits 31:13 of `clk_ctrl` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider run enable from the transfer engine |
| clk_ctrl | input | 32 | Clock control word: N in [7:0], E in [11:8], law select in [12] |
| sclk_tick | output | 1 | One-cycle strobe marking each serial clock edge |
| sclk_lvl | output | 1 | Serial clock level, idle 0 |

## Verification
Two of this block's functions can fall in the same cycle: a change to the control word, and the end-of-period tick that latches the setting. The bench provokes this by writing a new word exactly in the tick cycle where `sclk_lvl` is 1. It expects the new half-period to start on the very next cycle.

It also writes new words in cycles where the new setting must not be latched:

- in the mid-period tick cycle, where `sclk_lvl` is 0;
- as a change that is made and then withdrawn before the period ends.

In each of these cases it expects the old timing to run to the end of the period. Every sampled cycle of tick and level is compared with a position computed from the half-periods.

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int CNT_W = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [31:0] clk_ctrl,
  output logic        sclk_tick,
  output logic        sclk_lvl
);
  localparam int NW = 8;
  localparam int EW = 4;

  logic [CNT_W-1:0] cnt, half_q, half_nx;
  logic [EW-1:0]    e_eff;

  assign e_eff = (clk_ctrl[11:8] == '0) ? EW'(1) : clk_ctrl[11:8];

  always_comb begin
    if (clk_ctrl[12]) half_nx = CNT_W'(clk_ctrl[NW-1:0]);
    else              half_nx = (CNT_W'(1) << (e_eff - EW'(1))) - CNT_W'(1);
  end

  assign sclk_tick = en && (cnt == half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      half_q   <= '0;
      sclk_lvl <= 1'b0;
    end else if (!en) begin
      cnt      <= '0;
      half_q   <= half_nx;
      sclk_lvl <= 1'b0;
    end else if (sclk_tick) begin
      cnt      <= '0;
      sclk_lvl <= ~sclk_lvl;
      if (sclk_lvl) half_q <= half_nx;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk_lvl);
  p_tick_toggles_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_tick |=> sclk_lvl != $past(sclk_lvl));
  p_level_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sclk_tick) |=> $stable(sclk_lvl));
  p_latch_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(sclk_tick && sclk_lvl)) |=> $stable(half_q));
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt <= half_q);
endmodule

// File: tb/tb_sclk_divider.sv
module tb_sclk_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] clk_ctrl = '0;
  logic sclk_tick, sclk_lvl;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sclk_divider dut (.clk(clk), .rst_n(rst_n), .en(en), .clk_ctrl(clk_ctrl),
                    .sclk_tick(sclk_tick), .sclk_lvl(sclk_lvl));

  function automatic int half_of(logic [31:0] w);
    int e;
    if (w[12]) return int'(w[7:0]) + 1;
    e = int'(w[11:8]);
    if (e == 0) e = 1;
    return 1 << (e - 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ctrl_b written in cycle chg (chg < 0: none); withdrawn next cycle if revert
  task automatic run(string req, logic [31:0] ctrl_a, logic [31:0] ctrl_b,
                     int chg, bit revert, int ncyc);
    int ha, hb, h, j;
    bit sw;
    ha = half_of(ctrl_a);
    hb = half_of(ctrl_b);
    sw = (chg >= 0) && !revert && (chg <= 2*ha - 1);
    @(negedge clk);
    en = 1'b0;
    clk_ctrl = ctrl_a;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk({req, " R5 idle level"}, int'(sclk_lvl), 0);
    chk({req, " R5 idle tick"}, int'(sclk_tick), 0);
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      if (i > 0) @(negedge clk);
      if (i == chg) clk_ctrl = ctrl_b;
      if (revert && i == chg + 1) clk_ctrl = ctrl_a;
      #1;
      if (sw && i >= 2*ha) begin h = hb; j = i - 2*ha; end
      else begin h = ha; j = i; end
      chk({req, " R6 R7 tick"}, int'(sclk_tick), int'(((j + 1) % h) == 0));
      chk({req, " R7 level"}, int'(sclk_lvl), (j / h) % 2);
    end
    @(negedge clk);
    en = 1'b0;
    #1;
    chk({req, " R5 tick off"}, int'(sclk_tick), 0);
    @(negedge clk);
    #1;
    chk({req, " R5 level off"}, int'(sclk_lvl), 0);
  endtask

  initial begin
    #2;
    chk("R5 reset level", int'(sclk_lvl), 0);
    chk("R5 reset tick", int'(sclk_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 linear sweep, with E field and high bits set to check R3 R9
    for (int n = 0; n < 16; n++)
      run("R1 R3 R9 linear", 32'hFFFF_F000 | 32'(n), 32'h0, -1, 1'b0, 4*(n + 1));
    run("R1 linear max", 32'h0000_10FF, 32'h0, -1, 1'b0, 4*256);
    // R2 power-of-two sweep, R4 at E = 0, with N field set for R3
    for (int e = 0; e < 16; e++)
      run("R2 R4 R3 pow2", 32'(e << 8) | 32'h0000_00A5, 32'h0, -1, 1'b0,
          2*half_of(32'(e << 8)) + 8);
    run("R9 high bits pow2", 32'hFFFF_E300, 32'h0, -1, 1'b0, 24);
    // R8: change mid-period, at the rising tick, at the wrap, and withdrawn
    run("R8 mid change", 32'h0000_1002, 32'h0000_1000, 1, 1'b0, 20);
    run("R8 change at rising tick", 32'h0000_1003, 32'h0000_1001, 3, 1'b0, 24);
    run("R8 change at wrap", 32'h0000_0300, 32'h0000_1004, 7, 1'b0, 30);
    run("R8 change withdrawn", 32'h0000_1002, 32'h0000_1000, 2, 1'b1, 24);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual 1 expected 0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule